// File: doc/BRIEF.md
# Page-Mode External Bus Controller

This block turns the core's code-fetch, data-read and data-write requests into cycles on an 8-bit external memory bus with 16-bit addresses. It drives two byte-wide ports (a low port and a high port), an address-latch strobe, a program-store strobe for code reads, and read and write strobes for data. It also has a private path to an on-chip code ROM. The core makes requests through a valid/ready handshake: it holds `req_valid` and the request fields stable until `rsp_ready` pulses, and drops `req_valid` in the cycle after the pulse.

Two bus layouts can be chosen. In multiplexed layout the low port first carries address bits 7:0 and then the data byte, and the high port carries bits 15:8 for the whole cycle. In page layout the low port holds bits 7:0 for the whole cycle, and the high port first carries bits 15:8 and then the data byte. In page layout, a code fetch whose upper address byte equals the byte latched by the most recent address-latch cycle skips the address phase. A wait-state count from 0 to 3 lengthens every external strobe.

The external-access strap is captured while reset is held. With the strap at 1, code fetches below `ROM_BYTES` are served by the on-chip ROM and never reach the pins. With the strap at 0, every fetch goes off-chip.

Top module: `pgbus_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ale`, `rsp_ready`, `rom_en`, `lo_oe` and `hi_oe` are 0, and `psen_n`, `rd_n` and `wr_n` are 1.
- R2: A code fetch (`req_kind`=0) with the latched strap at 1 and address below `ROM_BYTES` is served on-chip. `rom_en` is high for one cycle, no bus strobe or `ale` appears, `rsp_ready` comes 2 cycles after acceptance, and `rsp_rdata` equals `rom_rdata`. Any other request uses the external bus.
- R3: The strap is sampled only while `rst_n` is low. Changes after reset do not alter steering.
- R4: A full external cycle lasts 4+W clocks, where W is `wait_cfg` captured at acceptance. `ale` is high only in its first clock, and `rsp_ready` is high in clock 5+W after the accepting edge.
- R5: Strobes are active-low and at most one is low at a time. It is `psen_n` for off-chip code, `rd_n` for `req_kind` 1 or 3, and `wr_n` for `req_kind` 2. The strobe stays low for 2+W clocks at the end of the cycle, and all strobes are high in the ready cycle and while idle.
- R6: In multiplexed layout (`page_mode`=0), the low port drives address bits 7:0 while `ale` is high, read data is sampled from `lo_in` on the last strobe clock, and the high port drives bits 15:8 throughout.
- R7: In page layout, the low port drives bits 7:0 throughout, the high port drives bits 15:8 in the address phase, and read data is sampled from `hi_in` on the last strobe clock.
- R8: In page layout, a code fetch whose bits 15:8 match the reference page skips the address phase. It has no `ale`, its strobe lasts 2+W clocks, and `rsp_ready` comes 3+W cycles after acceptance. A miss uses a full cycle.
- R9: Every `ale` cycle in page layout loads the reference page, whatever the access kind. Reset clears the reference, and no fetch is treated as a hit while `page_mode` is 0.
- R10: `rsp_ready` is a single-cycle pulse, and `rsp_rdata` holds the read byte while it is high.
- R11: During a write strobe, the data port is driven with the write byte: the low port in multiplexed layout, the high port in page layout. During a read strobe, that port is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; strap sampled while low |
| ext_access_strap | input | 1 | 1 allows on-chip code fetches |
| page_mode | input | 1 | 1 selects page layout |
| wait_cfg | input | WAIT_W | Wait states added to each external strobe |
| req_valid | input | 1 | Request present, held until ready |
| req_kind | input | 2 | 0 code fetch, 2 data write, 1 or 3 data read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte |
| rom_en | output | 1 | On-chip ROM read enable |
| rom_addr | output | ADDR_W | On-chip ROM address |
| rom_rdata | input | DATA_W | On-chip ROM data, valid while rom_en |
| lo_out | output | DATA_W | Low port output value |
| lo_oe | output | 1 | Low port drive enable |
| lo_in | input | DATA_W | Low port input value |
| hi_out | output | DATA_W | High port output value |
| hi_oe | output | 1 | High port drive enable |
| hi_in | input | DATA_W | High port input value |
| ale | output | 1 | Address latch strobe, high in the address clock |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
A corrupted phase counter shows up within the same transaction: the strobe window is too long or too short, or `rsp_ready` arrives in the wrong cycle. A stale or wrong reference page shows up on the next page-layout fetch, as an `ale` that should not be there, or as a skipped address phase that makes the bus model decode the wrong address and return the wrong byte. A wrong steering decision or a lost strap value is caught on the first code fetch near the ROM boundary, by the presence or absence of a program-store strobe and by the latency.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROM  = 2'd1,
      ST_BUS  = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

   localparam logic [1:0] KIND_CODE = 2'd0;
   localparam logic [1:0] KIND_WR   = 2'd2;
endpackage

// File: rtl/pgbus_steer.sv
module pgbus_steer #(
   parameter int ADDR_W    = 16,
   parameter int ROM_BYTES = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap,
   input  logic              is_code,
   input  logic [ADDR_W-1:0] addr,
   output logic              ea_lat,
   output logic              on_chip
);
   localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W+1)'(ROM_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) ea_lat <= strap;
   end

   assign on_chip = ea_lat && is_code && ({1'b0, addr} < ROM_LIMIT);
endmodule

// File: rtl/pgbus_page_track.sv
module pgbus_page_track #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_mode,
   input  logic              load,
   input  logic              load_pm,
   input  logic [PAGE_W-1:0] load_page,
   input  logic [PAGE_W-1:0] req_page,
   output logic              hit
);
   logic [PAGE_W-1:0] ref_q;
   logic              ref_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= '0;
         ref_vld <= 1'b0;
      end else if (!page_mode) begin
         ref_vld <= 1'b0;
      end else if (load) begin
         ref_q   <= load_page;
         ref_vld <= load_pm;
      end
   end

   assign hit = page_mode && ref_vld && (req_page == ref_q);
endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq
   import pgbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAIT_W-1:0] wait_cfg,
   input  logic              page_mode,
   input  logic              on_chip,
   input  logic              page_hit,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] lo_in,
   input  logic [DATA_W-1:0] hi_in,
   output logic              ph_bus,
   output logic              ph_ale,
   output logic              ph_strobe,
   output logic              rom_en,
   output logic              ready,
   output logic [1:0]        kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              pm_q,
   output logic [DATA_W-1:0] rdata_q
);
   localparam int CNT_W = $clog2(4 + (1 << WAIT_W));
   localparam logic [CNT_W-1:0] STROBE_FIRST = CNT_W'(2);
   localparam logic [CNT_W-1:0] BASE_LAST    = CNT_W'(3);

   seq_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [WAIT_W-1:0] wst_q;
   logic [CNT_W-1:0]  last_cnt;

   assign last_cnt = BASE_LAST + CNT_W'(wst_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         wst_q   <= '0;
         kind_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         pm_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               kind_q  <= req_kind;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               wst_q   <= wait_cfg;
               pm_q    <= page_mode;
               if (req_kind == KIND_CODE && on_chip) begin
                  st <= ST_ROM;
               end else begin
                  st  <= ST_BUS;
                  cnt <= (req_kind == KIND_CODE && page_hit) ? STROBE_FIRST : '0;
               end
            end
            ST_ROM: begin
               rdata_q <= rom_rdata;
               st      <= ST_DONE;
            end
            ST_BUS: begin
               if (cnt == last_cnt) begin
                  if (kind_q != KIND_WR) rdata_q <= pm_q ? hi_in : lo_in;
                  st <= ST_DONE;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ph_bus    = (st == ST_BUS);
   assign ph_ale    = ph_bus && (cnt == '0);
   assign ph_strobe = ph_bus && (cnt >= STROBE_FIRST);
   assign rom_en    = (st == ST_ROM);
   assign ready     = (st == ST_DONE);
endmodule

// File: rtl/pgbus_pins.sv
module pgbus_pins
   import pgbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              ph_bus,
   input  logic              ph_ale,
   input  logic              ph_strobe,
   input  logic [1:0]        kind_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              pm_q,
   output logic [DATA_W-1:0] lo_out,
   output logic              lo_oe,
   output logic [DATA_W-1:0] hi_out,
   output logic              hi_oe,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n
);
   logic is_code, is_wr, data_drive;

   assign is_code    = (kind_q == KIND_CODE);
   assign is_wr      = (kind_q == KIND_WR);
   assign data_drive = !ph_strobe || is_wr;

   assign ale    = ph_ale;
   assign psen_n = !(ph_strobe && is_code);
   assign wr_n   = !(ph_strobe && is_wr);
   assign rd_n   = !(ph_strobe && !is_code && !is_wr);

   always_comb begin
      if (pm_q) begin
         lo_oe  = ph_bus;
         lo_out = addr_q[DATA_W-1:0];
         hi_oe  = ph_bus && data_drive;
         hi_out = ph_strobe ? wdata_q : addr_q[ADDR_W-1:DATA_W];
      end else begin
         lo_oe  = ph_bus && data_drive;
         lo_out = ph_strobe ? wdata_q : addr_q[DATA_W-1:0];
         hi_oe  = ph_bus;
         hi_out = addr_q[ADDR_W-1:DATA_W];
      end
   end
endmodule

// File: rtl/pgbus_ctrl.sv
module pgbus_ctrl #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int WAIT_W    = 2,
   parameter int ROM_BYTES = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_access_strap,
   input  logic              page_mode,
   input  logic [WAIT_W-1:0] wait_cfg,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rom_en,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic [DATA_W-1:0] lo_out,
   output logic              lo_oe,
   input  logic [DATA_W-1:0] lo_in,
   output logic [DATA_W-1:0] hi_out,
   output logic              hi_oe,
   input  logic [DATA_W-1:0] hi_in,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n
);
   localparam int PAGE_W = ADDR_W - DATA_W;

   generate
      if (PAGE_W != DATA_W) begin : g_bad_split
         $error("pgbus_ctrl: ADDR_W must be twice DATA_W");
      end
      if (ROM_BYTES < 0 || ROM_BYTES > (1 << ADDR_W)) begin : g_bad_rom
         $error("pgbus_ctrl: ROM_BYTES outside the code space");
      end
      if (WAIT_W < 1 || WAIT_W > 3) begin : g_bad_wait
         $error("pgbus_ctrl: WAIT_W out of range");
      end
   endgenerate

   logic              ea_lat, on_chip, page_hit;
   logic              ph_bus, ph_ale, ph_strobe, pm_q;
   logic [1:0]        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   pgbus_steer #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) steer_i (
      .clk(clk), .rst_n(rst_n), .strap(ext_access_strap),
      .is_code(req_kind == pgbus_pkg::KIND_CODE), .addr(req_addr),
      .ea_lat(ea_lat), .on_chip(on_chip)
   );

   pgbus_page_track #(.PAGE_W(PAGE_W)) page_i (
      .clk(clk), .rst_n(rst_n), .page_mode(page_mode),
      .load(ph_ale), .load_pm(pm_q), .load_page(addr_q[ADDR_W-1:DATA_W]),
      .req_page(req_addr[ADDR_W-1:DATA_W]), .hit(page_hit)
   );

   pgbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .wait_cfg(wait_cfg),
      .page_mode(page_mode), .on_chip(on_chip), .page_hit(page_hit),
      .rom_rdata(rom_rdata), .lo_in(lo_in), .hi_in(hi_in),
      .ph_bus(ph_bus), .ph_ale(ph_ale), .ph_strobe(ph_strobe),
      .rom_en(rom_en), .ready(rsp_ready), .kind_q(kind_q), .addr_q(addr_q),
      .wdata_q(wdata_q), .pm_q(pm_q), .rdata_q(rsp_rdata)
   );

   pgbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
      .ph_bus(ph_bus), .ph_ale(ph_ale), .ph_strobe(ph_strobe),
      .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q), .pm_q(pm_q),
      .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   assign rom_addr = addr_q;
endmodule

// File: rtl/pgbus_ctrl_chk.sv
module pgbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ale,
   input logic psen_n,
   input logic rd_n,
   input logic wr_n,
   input logic lo_oe,
   input logic hi_oe,
   input logic rsp_ready,
   input logic rom_en,
   input logic pm_q,
   input logic ea_lat
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R5
   AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (psen_n && rd_n && wr_n)); // R4
   AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale); // R4
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready); // R10
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> (psen_n && rd_n && wr_n && !ale)); // R5
   AST_ROM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rom_en |-> (psen_n && rd_n && wr_n && !ale)); // R2
   AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(ea_lat)); // R3
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (pm_q ? hi_oe : lo_oe)); // R11
   AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !psen_n) |-> (pm_q ? (!hi_oe && lo_oe) : (!lo_oe && hi_oe))); // R11
endmodule

bind pgbus_ctrl pgbus_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
   .wr_n(wr_n), .lo_oe(lo_oe), .hi_oe(hi_oe), .rsp_ready(rsp_ready),
   .rom_en(rom_en), .pm_q(pm_q), .ea_lat(ea_lat)
);

// File: tb/pgbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgbus_ctrl_tb_top;
   localparam int ROMB = 16384;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, strap, page_mode, req_valid;
   logic [1:0]  wait_cfg, req_kind;
   logic [15:0] req_addr, rom_addr;
   logic [7:0]  req_wdata, rsp_rdata, rom_rdata, lo_out, lo_in, hi_out, hi_in;
   logic rsp_ready, rom_en, lo_oe, hi_oe, ale, psen_n, rd_n, wr_n;

   pgbus_ctrl #(.ADDR_W(16), .DATA_W(8), .WAIT_W(2), .ROM_BYTES(ROMB)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_access_strap(strap), .page_mode(page_mode),
      .wait_cfg(wait_cfg), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .rom_en(rom_en), .rom_addr(rom_addr),
      .rom_rdata(rom_rdata), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
      .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in), .ale(ale),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   int n_cmp = 0, n_bad = 0;
   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] code_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   function automatic logic [7:0] data_val(input logic [15:0] a);
      return a[7:0] + a[15:8] + 8'h11;
   endfunction

   // external memory model with its own address latch
   logic [7:0]  lo_lat = 8'h00, hi_lat = 8'h00;
   logic [15:0] cur_addr;
   logic [7:0]  bus_v;
   always @(negedge clk) if (ale) begin lo_lat <= lo_out; hi_lat <= hi_out; end
   assign cur_addr  = page_mode ? {hi_lat, lo_out} : {hi_out, lo_lat};
   assign bus_v     = !psen_n ? code_val(cur_addr) : data_val(cur_addr);
   assign lo_in     = (!page_mode && (!psen_n || !rd_n)) ? bus_v : 8'hEE;
   assign hi_in     = ( page_mode && (!psen_n || !rd_n)) ? bus_v : 8'hEE;
   assign rom_rdata = rom_addr[7:0] ^ 8'hC3;

   bit ea_exp, pg_vld;
   logic [7:0]  pg_ref;
   logic [15:0] last_a = 16'h0;

   task automatic do_reset(input bit ea, input bit pm);
      rst_n = 1'b0; strap = ea; page_mode = pm; req_valid = 1'b0;
      req_kind = 2'd0; req_addr = '0; req_wdata = '0; wait_cfg = '0;
      repeat (3) @(negedge clk);
      chk(!ale && psen_n && rd_n && wr_n && !rsp_ready && !rom_en && !lo_oe && !hi_oe,
          "R1 reset", {ale, psen_n, rd_n, wr_n}, 4'b0111);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ale && psen_n && rd_n && wr_n && !rsp_ready && !lo_oe && !hi_oe,
          "R1 after reset", {ale, psen_n, rd_n, wr_n}, 4'b0111);
      ea_exp = ea; pg_vld = 1'b0;
   endtask

   task automatic txn(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                      input logic [1:0] w);
      bit onchip, hit, is_code, is_wr;
      int lat = 0, ales = 0, strb = 0, rom_cyc = 0, exp_lat;
      bit bad_kind = 0;
      logic [15:0] seen_a = '0;
      logic [7:0]  seen_w = '0, exp_d;
      is_code = (k == 2'd0);
      is_wr   = (k == 2'd2);
      onchip  = is_code && ea_exp && (a < ROMB);
      hit     = !onchip && is_code && page_mode && pg_vld && (a[15:8] == pg_ref);
      exp_lat = onchip ? 2 : (hit ? 3 + w : 5 + w);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; wait_cfg = w;
      do begin
         @(negedge clk);
         lat++;
         if (ale) ales++;
         if (rom_en) rom_cyc++;
         if (!psen_n || !rd_n || !wr_n) begin
            strb++;
            seen_a = cur_addr;
            if (!wr_n) seen_w = page_mode ? hi_out : lo_out;
            if (is_code ? psen_n : (is_wr ? wr_n : rd_n)) bad_kind = 1;
         end
      end while (!rsp_ready && lat < 30);
      req_valid = 1'b0;
      chk(lat == exp_lat, onchip ? "R2 rom latency" : (hit ? "R8 hit latency" : "R4 cycle latency"),
          lat, exp_lat);
      chk(ales == ((onchip || hit) ? 0 : 1), hit ? "R8 no ale on hit" : "R4 ale count",
          ales, (onchip || hit) ? 0 : 1);
      chk(strb == (onchip ? 0 : 2 + w), "R5 strobe width", strb, onchip ? 0 : 2 + w);
      chk(rom_cyc == (onchip ? 1 : 0), "R2 rom enable", rom_cyc, onchip ? 1 : 0);
      chk(!bad_kind, "R5 strobe kind", k, k);
      if (!onchip)
         chk(seen_a == a, page_mode ? "R7 page address" : "R6 mux address", seen_a, a);
      if (is_wr) chk(seen_w == wd, "R11 write data", seen_w, wd);
      else begin
         exp_d = onchip ? (a[7:0] ^ 8'hC3) : (is_code ? code_val(a) : data_val(a));
         chk(rsp_rdata == exp_d, page_mode ? "R7 read data" : "R10 read data", rsp_rdata, exp_d);
      end
      @(negedge clk);
      chk(!rsp_ready, "R10 ready pulse", rsp_ready, 0);
      if (!onchip && !hit && page_mode) begin pg_ref = a[15:8]; pg_vld = 1'b1; end
      last_a = a;
   endtask

   task automatic rand_txn();
      int r = $urandom % 8, s = $urandom % 4;
      logic [1:0] k;
      logic [15:0] a;
      k = (r < 4) ? 2'd0 : (r < 6 ? ($urandom % 2 == 0 ? 2'd1 : 2'd3) : 2'd2);
      case (s)
         0: a = 16'($urandom);
         1: a = {last_a[15:8], 8'($urandom)};
         2: a = 16'(ROMB - 1 + int'($urandom % 2));
         default: a = {last_a[15:8], last_a[7:0] + 8'd1};
      endcase
      txn(k, a, 8'($urandom), 2'($urandom));
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(150000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4471));
      // multiplexed layout, strap high
      do_reset(1'b1, 1'b0);
      txn(2'd0, 16'h0000, 8'h00, 2'd0);          // R2 on-chip
      txn(2'd0, 16'h3FFF, 8'h00, 2'd3);          // R2 last on-chip byte
      txn(2'd0, 16'h4000, 8'h00, 2'd0);          // R2 first off-chip byte
      txn(2'd1, 16'h0010, 8'h00, 2'd1);          // R6 data read never steered
      txn(2'd2, 16'h1234, 8'hA5, 2'd2);          // R11 write
      txn(2'd0, 16'h4001, 8'h00, 2'd0);          // R9 no hit with page_mode 0
      txn(2'd0, 16'h4002, 8'h00, 2'd0);
      strap = 1'b0;
      @(negedge clk);
      txn(2'd0, 16'h0100, 8'h00, 2'd0);          // R3 strap change ignored
      repeat (120) rand_txn();
      // page layout, strap low: everything off-chip
      do_reset(1'b0, 1'b1);
      txn(2'd0, 16'h0000, 8'h00, 2'd0);          // R8 miss
      txn(2'd0, 16'h0001, 8'h00, 2'd0);          // R8 hit, minimum
      txn(2'd0, 16'h0002, 8'h00, 2'd3);          // R8 hit with waits
      txn(2'd1, 16'h0123, 8'h00, 2'd1);          // R7 data read
      txn(2'd0, 16'h0003, 8'h00, 2'd0);          // R9 reference moved by data cycle
      txn(2'd2, 16'h0210, 8'h3C, 2'd0);          // R11 write on high port
      txn(2'd0, 16'h0211, 8'h00, 2'd0);          // R9 hit on write page
      repeat (150) rand_txn();
      // page layout, strap high
      do_reset(1'b1, 1'b1);
      txn(2'd0, 16'h4100, 8'h00, 2'd0);          // R8 miss after reset clears reference
      txn(2'd0, 16'h0100, 8'h00, 2'd0);          // R2 on-chip in page layout
      txn(2'd0, 16'h41FF, 8'h00, 2'd2);          // R8 hit survives on-chip fetch
      repeat (150) rand_txn();
      finish_run();
   end
endmodule